// File: doc/BRIEF.md
# SHA-512 Sigma Instruction Unit

This execution unit sits beside the integer pipeline of a 64-bit core. It looks at each issued instruction word, picks out the four scalar SHA-512 helper operations (the two message-schedule sigmas and the two round sums), and works out the selected rotate/shift/XOR mix of the source operand. The result, the destination index and a valid strobe are registered and appear one clock after issue, ready for the write-back stage.

Each function XORs three copies of the operand. For both sum operations all three terms are right rotations. For both sigma operations the first two terms are rotations and the third is a logical right shift. If the hash extension is disabled, or the unit is built for a non-64-bit base, a word the unit recognises raises an illegal-instruction flag in place of a result. Words the unit does not recognise are left to other units, and both of its strobes stay low for them.

Top module: `sha512_mix_unit`

## Requirements
- R1: A word is claimed when bits 6:0 = 0010011, bits 14:12 = 001, bits 31:25 = 0001000 and bits 24:20 hold one of 00110, 00111, 00100 or 00101. The destination index is taken from bits 11:7. Bits 19:15 have no effect on any output.
- R2: Selector 00110 yields ROTR(x,1) ^ ROTR(x,8) ^ (x >> 7), where >> is a logical shift.
- R3: Selector 00111 yields ROTR(x,19) ^ ROTR(x,61) ^ (x >> 6), where >> is a logical shift.
- R4: Selector 00100 yields ROTR(x,28) ^ ROTR(x,34) ^ ROTR(x,39).
- R5: Selector 00101 yields ROTR(x,14) ^ ROTR(x,18) ^ ROTR(x,41).
- R6: An accepted issue (issue_vld high, word claimed, hash_en high) sets res_vld, res_out and dst_idx on the next clock edge. In any cycle without an accepted issue, res_vld is low after the next edge.
- R7: A claimed, issued word with hash_en low sets bad_ins on the next edge, keeps res_vld low and leaves res_out and dst_idx unchanged. res_vld and bad_ins are never high together.
- R8: An issued word that is not claimed leaves both res_vld and bad_ins low after the next edge.
- R9: An accepted issue whose destination index is 0 still raises res_vld, and res_out is zero.
- R10: A synchronous active-high rst clears res_vld, bad_ins, res_out and dst_idx on the next edge, and it overrides a simultaneous issue.
- R11: res_out and dst_idx keep their values in every cycle without an accepted issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | An instruction is offered this cycle |
| ins_word | input | 32 | Instruction word |
| src_val | input | 64 | Source operand value |
| hash_en | input | 1 | SHA-512 hash extension enabled |
| res_out | output | 64 | Registered result |
| dst_idx | output | 5 | Registered destination register index |
| res_vld | output | 1 | Result is valid this cycle |
| bad_ins | output | 1 | Claimed word was illegal in the current configuration |

## Verification
On every cycle the assertions check the strobe protocol: an accept is followed by valid, a trap by the illegal flag with no write, an unclaimed word by silence on both strobes, the result and index holding between accepts, and a zero result whenever the destination is zero. Only the bench scenarios can show that the four mixes compute the right values for chosen operands, that the selector and fixed-field patterns are decoded exactly (including the near-miss encodings and the unused source field), and that reset overrides an issue in the same cycle.

// File: rtl/sha512_mix_pkg.sv
package sha512_mix_pkg;
  localparam int XW = 64;
  localparam int IW = 32;
  localparam int RW = 5;

  typedef enum logic [1:0] {OP_SG0 = 2'd0, OP_SG1 = 2'd1, OP_SM0 = 2'd2, OP_SM1 = 2'd3} mix_op_e;

  localparam logic [6:0] MAJ_OPC  = 7'b0010011;
  localparam logic [2:0] MIN_F3   = 3'b001;
  localparam logic [6:0] HI_FIELD = 7'b0001000;
  localparam logic [4:0] SEL_SG0  = 5'b00110;
  localparam logic [4:0] SEL_SG1  = 5'b00111;
  localparam logic [4:0] SEL_SM0  = 5'b00100;
  localparam logic [4:0] SEL_SM1  = 5'b00101;

  function automatic logic [XW-1:0] rotr(input logic [XW-1:0] x, input int unsigned n);
    logic [2*XW-1:0] dbl;
    dbl = {x, x} >> n;
    return dbl[XW-1:0];
  endfunction

  // Three-term mix; the last term is a shift when last_is_shift is set
  function automatic logic [XW-1:0] mix3(input logic [XW-1:0] x, input int unsigned a,
                                         input int unsigned b, input int unsigned c,
                                         input logic last_is_shift);
    logic [XW-1:0] t3;
    t3 = last_is_shift ? (x >> c) : rotr(x, c);
    return rotr(x, a) ^ rotr(x, b) ^ t3;
  endfunction

  function automatic logic [XW-1:0] mix_by_op(input mix_op_e op, input logic [XW-1:0] x);
    case (op)
      OP_SG0:  return mix3(x, 1, 8, 7, 1'b1);
      OP_SG1:  return mix3(x, 19, 61, 6, 1'b1);
      OP_SM0:  return mix3(x, 28, 34, 39, 1'b0);
      default: return mix3(x, 14, 18, 41, 1'b0);
    endcase
  endfunction
endpackage

// File: rtl/sha512_mix_decode.sv
module sha512_mix_decode
  import sha512_mix_pkg::*;
(
  input  logic [IW-1:0] word,
  output logic          claim,
  output mix_op_e       op,
  output logic [RW-1:0] rd
);
  logic fixed_ok;
  logic sel_ok;

  assign fixed_ok = (word[6:0] == MAJ_OPC) && (word[14:12] == MIN_F3) &&
                    (word[31:25] == HI_FIELD);

  always_comb begin
    sel_ok = 1'b1;
    op     = OP_SG0;
    case (word[24:20])
      SEL_SG0: op = OP_SG0;
      SEL_SG1: op = OP_SG1;
      SEL_SM0: op = OP_SM0;
      SEL_SM1: op = OP_SM1;
      default: sel_ok = 1'b0;
    endcase
  end

  assign claim = fixed_ok && sel_ok;
  assign rd    = word[11:7];
endmodule

// File: rtl/sha512_mix_core.sv
module sha512_mix_core
  import sha512_mix_pkg::*;
#(
  parameter int NOPS = 4
) (
  input  mix_op_e       op,
  input  logic [XW-1:0] x,
  output logic [XW-1:0] y
);
  logic [XW-1:0] lane [NOPS];

  for (genvar g = 0; g < NOPS; g++) begin : g_lane
    always_comb lane[g] = mix_by_op(mix_op_e'(2'(g)), x);
  end

  assign y = lane[op];
endmodule

// File: rtl/sha512_mix_unit.sv
module sha512_mix_unit
  import sha512_mix_pkg::*;
#(
  parameter bit BASE_IS_64 = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_vld,
  input  logic [31:0]   ins_word,
  input  logic [63:0]   src_val,
  input  logic          hash_en,
  output logic [63:0]   res_out,
  output logic [4:0]    dst_idx,
  output logic          res_vld,
  output logic          bad_ins
);
  logic          claim;
  mix_op_e       dec_op;
  logic [RW-1:0] dec_rd;
  logic [XW-1:0] mix_val;
  logic          acc_hit;
  logic          trap_hit;
  logic [4:0]    unused_src_idx;

  assign unused_src_idx = ins_word[19:15];

  sha512_mix_decode i_dec (
    .word  (ins_word),
    .claim (claim),
    .op    (dec_op),
    .rd    (dec_rd)
  );

  sha512_mix_core #(.NOPS(4)) i_core (
    .op (dec_op),
    .x  (src_val),
    .y  (mix_val)
  );

  assign acc_hit  = issue_vld && claim && hash_en && BASE_IS_64;
  assign trap_hit = issue_vld && claim && !(hash_en && BASE_IS_64);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      bad_ins <= 1'b0;
      res_out <= '0;
      dst_idx <= '0;
    end else begin
      res_vld <= acc_hit;
      bad_ins <= trap_hit;
      if (acc_hit) begin
        dst_idx <= dec_rd;
        res_out <= (dec_rd == '0) ? '0 : mix_val;
      end
    end
  end
endmodule

// File: rtl/sha512_mix_chk.sv
module sha512_mix_chk (
  input logic        clk,
  input logic        rst,
  input logic        issue_vld,
  input logic        claim,
  input logic        acc_hit,
  input logic        trap_hit,
  input logic [63:0] res_out,
  input logic [4:0]  dst_idx,
  input logic        res_vld,
  input logic        bad_ins
);
  AST_ACCEPT_GIVES_VLD: assert property (@(posedge clk) disable iff (rst) acc_hit |=> res_vld); // R6
  AST_NO_VLD_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (rst) !acc_hit |=> !res_vld); // R6
  AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst) trap_hit |=> bad_ins && !res_vld && $stable(res_out)); // R7
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(res_vld && bad_ins)); // R7
  AST_UNCLAIMED_SILENT: assert property (@(posedge clk) disable iff (rst) (issue_vld && !claim) |=> !res_vld && !bad_ins); // R8
  AST_ZERO_DEST: assert property (@(posedge clk) disable iff (rst) (res_vld && dst_idx == 5'd0) |-> res_out == 64'd0); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !acc_hit |=> $stable(res_out) && $stable(dst_idx)); // R11
endmodule

bind sha512_mix_unit sha512_mix_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .issue_vld (issue_vld),
  .claim     (claim),
  .acc_hit   (acc_hit),
  .trap_hit  (trap_hit),
  .res_out   (res_out),
  .dst_idx   (dst_idx),
  .res_vld   (res_vld),
  .bad_ins   (bad_ins)
);

// File: tb/test_sha512_mix_unit.sv
module test_sha512_mix_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_vld = 1'b0;
  logic [31:0] ins_word = '0;
  logic [63:0] src_val = '0;
  logic        hash_en = 1'b0;
  logic [63:0] res_out;
  logic [4:0]  dst_idx;
  logic        res_vld;
  logic        bad_ins;

  always #10 clk = ~clk;

  sha512_mix_unit i_sha512_mix_unit (
    .clk(clk), .rst(rst), .issue_vld(issue_vld), .ins_word(ins_word),
    .src_val(src_val), .hash_en(hash_en), .res_out(res_out),
    .dst_idx(dst_idx), .res_vld(res_vld), .bad_ins(bad_ins)
  );

  typedef struct {
    logic        vld;
    logic        bad;
    logic [63:0] res;
    logic [4:0]  dst;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad = 0;
  logic [63:0] m_res = '0;
  logic [4:0]  m_dst = '0;

  function automatic logic [63:0] ror(logic [63:0] v, int n);
    return (v >> n) | (v << (64 - n));
  endfunction

  function automatic logic [31:0] mk(logic [6:0] hi, logic [4:0] sel, logic [4:0] rs,
                                     logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
    return {hi, sel, rs, f3, rd, opc};
  endfunction

  function automatic logic [31:0] ok_word(logic [4:0] sel, logic [4:0] rd);
    return mk(7'b0001000, sel, 5'd9, 3'b001, rd, 7'b0010011);
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic r, logic iss, logic [31:0] w, logic [63:0] x, logic en, string tag);
    exp_t e;
    logic claimed;
    logic [63:0] f;
    @(negedge clk);
    rst = r; issue_vld = iss; ins_word = w; src_val = x; hash_en = en;
    claimed = (w[6:0] == 7'b0010011) && (w[14:12] == 3'b001) && (w[31:25] == 7'b0001000) &&
              (w[24:20] inside {5'b00110, 5'b00111, 5'b00100, 5'b00101});
    case (w[24:20])
      5'b00110: f = ror(x, 1) ^ ror(x, 8) ^ (x >> 7);
      5'b00111: f = ror(x, 19) ^ ror(x, 61) ^ (x >> 6);
      5'b00100: f = ror(x, 28) ^ ror(x, 34) ^ ror(x, 39);
      default:  f = ror(x, 14) ^ ror(x, 18) ^ ror(x, 41);
    endcase
    e.vld = 1'b0; e.bad = 1'b0; e.tag = tag;
    if (r) begin
      m_res = '0; m_dst = '0;
    end else if (iss && claimed && en) begin
      e.vld = 1'b1;
      m_dst = w[11:7];
      m_res = (w[11:7] == 5'd0) ? 64'd0 : f;
    end else if (iss && claimed) begin
      e.bad = 1'b1;
    end
    e.res = m_res; e.dst = m_dst;
    exp_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(e.tag, "res_vld", 64'(res_vld), 64'(e.vld));
        check(e.tag, "bad_ins", 64'(bad_ins), 64'(e.bad));
        check(e.tag, "res_out", res_out, e.res);
        check(e.tag, "dst_idx", 64'(dst_idx), 64'(e.dst));
      end
    end
  end

  initial begin : watchdog
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    logic [63:0] xs [5];
    xs[0] = 64'h0123456789abcdef; xs[1] = 64'hffffffffffffffff; xs[2] = 64'h1;
    xs[3] = 64'h8000000000000000; xs[4] = 64'hdeadbeefcafef00d;
    repeat (3) @(negedge clk);
    #1;
    // R10: state after reset
    check("R10", "res_vld after reset", 64'(res_vld), 64'd0);
    check("R10", "bad_ins after reset", 64'(bad_ins), 64'd0);
    for (int i = 0; i < 5; i++) begin
      step(0, 1, ok_word(5'b00110, 5'(i + 1)), xs[i], 1, "R2");
      step(0, 1, ok_word(5'b00111, 5'(i + 7)), xs[i], 1, "R3");
      step(0, 1, ok_word(5'b00100, 5'(i + 13)), xs[i], 1, "R4");
      step(0, 1, ok_word(5'b00101, 5'(i + 20)), xs[i], 1, "R5");
    end
    // R6: idle cycles drop valid; R11: result and index hold
    step(0, 0, ok_word(5'b00110, 5'd3), xs[2], 1, "R6");
    step(0, 0, ok_word(5'b00111, 5'd4), xs[0], 1, "R11");
    step(0, 1, ok_word(5'b00101, 5'd31), xs[4], 1, "R6");
    step(0, 1, ok_word(5'b00100, 5'd30), xs[3], 1, "R6");
    // R1: source field has no effect
    step(0, 1, mk(7'b0001000, 5'b00110, 5'd0, 3'b001, 5'd5, 7'b0010011), xs[0], 1, "R1");
    step(0, 1, mk(7'b0001000, 5'b00110, 5'd31, 3'b001, 5'd5, 7'b0010011), xs[0], 1, "R1");
    // R7: extension disabled traps, no write
    step(0, 1, ok_word(5'b00111, 5'd12), xs[1], 0, "R7");
    step(0, 1, ok_word(5'b00100, 5'd0), xs[4], 0, "R7");
    step(0, 0, ok_word(5'b00100, 5'd0), xs[4], 0, "R7");
    // R8: near-miss encodings are not claimed
    step(0, 1, ok_word(5'b00000, 5'd6), xs[0], 1, "R8");
    step(0, 1, ok_word(5'b00010, 5'd6), xs[0], 0, "R8");
    step(0, 1, mk(7'b0001001, 5'b00110, 5'd1, 3'b001, 5'd6, 7'b0010011), xs[0], 1, "R8");
    step(0, 1, mk(7'b0001000, 5'b00110, 5'd1, 3'b000, 5'd6, 7'b0010011), xs[0], 1, "R8");
    step(0, 1, mk(7'b0001000, 5'b00110, 5'd1, 3'b001, 5'd6, 7'b0110011), xs[0], 0, "R8");
    // R9: destination zero
    step(0, 1, ok_word(5'b00101, 5'd0), xs[0], 1, "R9");
    step(0, 1, ok_word(5'b00111, 5'd0), xs[1], 1, "R9");
    step(0, 1, ok_word(5'b00110, 5'd17), xs[4], 1, "R1");
    // R10: reset overrides a simultaneous accepted issue
    step(1, 1, ok_word(5'b00110, 5'd8), xs[0], 1, "R10");
    step(0, 0, 32'd0, 64'd0, 1, "R10");
    step(0, 1, ok_word(5'b00100, 5'd2), xs[2], 1, "R4");
    step(0, 0, 32'd0, 64'd0, 0, "R11");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule